// File: doc/BRIEF.md
# Four-timeslot channel frame handler

This block handles a serial frame of 32 eight-bit timeslots, one bit per clock and most significant bit first. It sends the frame on `tx_dout` and receives it on `rx_din`. The slots form eight channels of four slots each. Slot 4n carries the first B byte of channel n and slot 4n+1 the second. Slot 4n+2 carries the monitor byte. Slot 4n+3 carries the signalling byte: a 2-bit D field, a 4-bit C/I field, then the MR bit and the MX bit.

Each slot has a 4-bit handling code, stored once for the transmit (downstream) direction and once for the receive (upstream) direction. The codes sit in a shadow store that can be written one slot at a time, filled across all channels for one slot pair, or cleared. The shadow is copied into the active store at the end of the last bit of each frame, so a change never splits a frame.

A sync FSM has two states. `ST_HUNT` is entered from reset and after a missing frame sync; the line idles in this state. `ST_RUN` is entered on any `fsync` pulse. In `ST_RUN`, an `fsync` that arrives mid-frame restarts the frame at slot 0. If `fsync` is absent in the cycle that follows the last bit of a frame, the FSM returns to `ST_HUNT`.

Top module: `iom_frame_handler`

## Requirements
- R1: During and after reset, every code in both directions is 0 (free), `tx_dout` is 1, and `rx_valid`, `rx_d_valid`, `rx_byte`, `rx_slot`, `rx_d` and `rx_ci` are 0.
- R2: In the cycle where `fsync` is high, bit 7 of slot 0 is on the line. Until the first `fsync`, `tx_dout` is 1 and received bits are dropped.
- R3: Bit b (counting from 0) of slot s is on the line 8*s + b cycles after the `fsync` cycle, sent as byte bit 7-b. With a non-zero down code, slot 4n sends `tx_b1[8n+:8]`, slot 4n+1 sends `tx_b2[8n+:8]` and slot 4n+2 sends `tx_mon[8n+:8]`.
- R4: Slot 4n+3 sends {`tx_d[2n+:2]`, `tx_ci[4n+:4]`, MR, MX} from MSB to LSB. MR and MX are `tx_mr[n]` and `tx_mx[n]`, except where R5 forces them.
- R5: When the down code of slot 4n+3 is 2 (handled) and `hs_mode` is 0 (no handshake), MR and MX are both sent as 1. With `hs_mode`=1 or code 1 (raw), they come from the inputs.
- R6: A slot whose down code is 0 is sent as all ones. A slot whose up code is 0 produces no `rx_valid` and leaves the rx outputs unchanged.
- R7: One cycle after the last bit of a slot whose up code is non-zero, `rx_valid` is high for one cycle, with the received byte on `rx_byte` and the slot number on `rx_slot`.
- R8: When up code 2 is set on slot 4n+3, bit n of `rx_d_valid` pulses, alone, together with that `rx_valid`, with `rx_d` = received bits 7:6 and `rx_ci` = bits 5:2.
- R9: Up and down codes are stored apart. `cm_dir`=0 writes up and `cm_dir`=1 writes down.
- R10: `cm_we` writes `cm_code` to slot `cm_addr`. `cm_init` writes `cm_code` to slots 4n+2p and 4n+2p+1 of every channel n, where p=`cm_pair`. `cm_clr` zeroes both directions. When several are high in one cycle, clear wins over init, and init wins over write.
- R11: The active codes take the shadow value, including a write in that same cycle, at the clock edge that ends the last bit of a frame. While out of sync they take it at every edge. Between those edges they do not change.
- R12: If `fsync` is not high in the cycle after the last bit of a frame, the block returns to `ST_HUNT` and idles as in R2. An `fsync` during a frame restarts the frame at slot 0, bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame sync, high during bit 7 of slot 0 |
| rx_din | input | 1 | Received serial data |
| tx_dout | output | 1 | Transmitted serial data |
| hs_mode | input | 1 | 1 = handshake, MR/MX from inputs; 0 = forced high |
| cm_we | input | 1 | Single code write |
| cm_init | input | 1 | Pair write across all channels |
| cm_clr | input | 1 | Clear all codes |
| cm_dir | input | 1 | 0 = up store, 1 = down store |
| cm_pair | input | 1 | Pair for init: 0 = B slots, 1 = monitor/signalling |
| cm_addr | input | 5 | Slot for a single write |
| cm_code | input | 4 | Code to store |
| tx_b1 | input | 64 | First B byte, channel n at [8n+:8] |
| tx_b2 | input | 64 | Second B byte per channel |
| tx_mon | input | 64 | Monitor byte per channel |
| tx_d | input | 16 | D field, channel n at [2n+:2] |
| tx_ci | input | 32 | C/I field, channel n at [4n+:4] |
| tx_mr | input | 8 | MR bit per channel |
| tx_mx | input | 8 | MX bit per channel |
| rx_valid | output | 1 | Received byte strobe |
| rx_slot | output | 5 | Slot of the received byte |
| rx_byte | output | 8 | Received byte |
| rx_d_valid | output | 8 | One-hot D strobe per channel |
| rx_d | output | 2 | Received D field |
| rx_ci | output | 4 | Received C/I field |

## Verification
The bench runs a reference model next to the block and goes after these cases:
- A code written in the middle of a frame. A design that applied it at once would change slots later in that same frame.
- Handled signalling slots in both handshake modes. A design with the MR/MX force wrong would send input bits where ones belong, or the reverse.
- A mid-frame `fsync` and a missing one. A design with a weak sync FSM would keep counting from a stale position, or keep sending after sync was lost.
- A clear in mid-frame, pair fills, and write priority. Wrong priority would leave stale codes; a slip in the pair decode would fill the wrong slots. Either shows up as wrong bytes on the line or wrong `rx_valid` strobes.

// File: rtl/iomh_pkg.sv
package iomh_pkg;
    typedef logic [3:0] code_t;

    localparam code_t CODE_FREE    = 4'h0;
    localparam code_t CODE_RAW     = 4'h1;
    localparam code_t CODE_HANDLED = 4'h2;

    localparam int BYTE_W     = 8;
    localparam int SLOTS_PER_CH = 4;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_RUN  = 1'b1
    } sync_state_t;
endpackage

// File: rtl/iomh_timing.sv
module iomh_timing #(
    parameter int NSLOT = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fsync,
    output logic                       synced,
    output logic [$clog2(NSLOT)-1:0]   slot,
    output logic [2:0]                 bitn,
    output logic                       load
);
    import iomh_pkg::*;

    localparam int SW = $clog2(NSLOT);
    localparam int PW = SW + 3;
    localparam logic [PW-1:0] POS_MAX = '1;

    sync_state_t       state, state_nxt;
    logic [PW-1:0]     pos;
    logic [PW-1:0]     cur_pos;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nxt;
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_HUNT: if (fsync) state_nxt = ST_RUN;
            ST_RUN:  if (!fsync && pos == POS_MAX) state_nxt = ST_HUNT;
        endcase
    end

    // outputs
    always_comb begin
        synced  = fsync || (state == ST_RUN && pos != POS_MAX);
        cur_pos = fsync ? '0 : pos + 1'b1;
        slot    = cur_pos[PW-1:3];
        bitn    = cur_pos[2:0];
        load    = !synced || (cur_pos == POS_MAX);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      pos <= POS_MAX;
        else if (synced) pos <= cur_pos;
        else             pos <= POS_MAX;
    end

    AST_SYNC_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> state == ST_RUN); // R2
endmodule

// File: rtl/iomh_ctrl_mem.sv
module iomh_ctrl_mem #(
    parameter int NSLOT = 32
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               we,
    input  logic                               init,
    input  logic                               clr,
    input  logic                               dir,
    input  logic                               pair,
    input  logic [$clog2(NSLOT)-1:0]           addr,
    input  iomh_pkg::code_t                    code,
    input  logic                               load,
    output iomh_pkg::code_t [NSLOT-1:0]        act_up,
    output iomh_pkg::code_t [NSLOT-1:0]        act_dn
);
    import iomh_pkg::*;

    code_t [NSLOT-1:0] shd_up, shd_dn;
    code_t [NSLOT-1:0] nxt_up, nxt_dn;

    always_comb begin
        nxt_up = shd_up;
        nxt_dn = shd_dn;
        if (clr) begin
            nxt_up = '0;
            nxt_dn = '0;
        end else if (init) begin
            for (int i = 0; i < NSLOT; i++) begin
                if (((i / 2) % 2) == int'(pair)) begin
                    if (dir) nxt_dn[i] = code;
                    else     nxt_up[i] = code;
                end
            end
        end else if (we) begin
            if (dir) nxt_dn[addr] = code;
            else     nxt_up[addr] = code;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_up <= '0;
            shd_dn <= '0;
            act_up <= '0;
            act_dn <= '0;
        end else begin
            shd_up <= nxt_up;
            shd_dn <= nxt_dn;
            if (load) begin
                act_up <= nxt_up;
                act_dn <= nxt_dn;
            end
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (shd_up == '0 && shd_dn == '0)); // R10
    AST_ACT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(act_up) && $stable(act_dn))); // R11
endmodule

// File: rtl/iomh_tx.sv
module iomh_tx #(
    parameter int NCH = 8
) (
    input  logic                                    synced,
    input  logic [$clog2(NCH*4)-1:0]                slot,
    input  logic [2:0]                              bitn,
    input  iomh_pkg::code_t [NCH*4-1:0]             act_dn,
    input  logic                                    hs_mode,
    input  logic [NCH*8-1:0]                        tx_b1,
    input  logic [NCH*8-1:0]                        tx_b2,
    input  logic [NCH*8-1:0]                        tx_mon,
    input  logic [NCH*2-1:0]                        tx_d,
    input  logic [NCH*4-1:0]                        tx_ci,
    input  logic [NCH-1:0]                          tx_mr,
    input  logic [NCH-1:0]                          tx_mx,
    output logic                                    tx_dout
);
    import iomh_pkg::*;

    localparam int SW = $clog2(NCH*4);

    logic [SW-3:0]       ch;
    code_t               code;
    logic [BYTE_W-1:0]   sel;
    logic                force_hi;

    always_comb begin
        ch       = slot[SW-1:2];
        code     = act_dn[slot];
        force_hi = 1'b0;
        unique case (slot[1:0])
            2'd0: sel = tx_b1[int'(ch)*8 +: 8];
            2'd1: sel = tx_b2[int'(ch)*8 +: 8];
            2'd2: sel = tx_mon[int'(ch)*8 +: 8];
            2'd3: begin
                force_hi = (code == CODE_HANDLED) && !hs_mode;
                sel = {tx_d[int'(ch)*2 +: 2], tx_ci[int'(ch)*4 +: 4],
                       tx_mr[ch] | force_hi, tx_mx[ch] | force_hi};
            end
        endcase
        if (!synced || code == CODE_FREE) tx_dout = 1'b1;
        else                              tx_dout = sel[3'd7 - bitn];
    end
endmodule

// File: rtl/iomh_rx.sv
module iomh_rx #(
    parameter int NCH = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rx_din,
    input  logic                                synced,
    input  logic [$clog2(NCH*4)-1:0]            slot,
    input  logic [2:0]                          bitn,
    input  iomh_pkg::code_t [NCH*4-1:0]         act_up,
    output logic                                rx_valid,
    output logic [$clog2(NCH*4)-1:0]            rx_slot,
    output logic [7:0]                          rx_byte,
    output logic [NCH-1:0]                      rx_d_valid,
    output logic [1:0]                          rx_d,
    output logic [3:0]                          rx_ci
);
    import iomh_pkg::*;

    localparam int SW = $clog2(NCH*4);

    logic [6:0]     sh;
    logic [7:0]     full;
    code_t          code;
    logic [SW-3:0]  ch;

    always_comb begin
        full = {sh, rx_din};
        code = act_up[slot];
        ch   = slot[SW-1:2];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh         <= '0;
            rx_valid   <= 1'b0;
            rx_slot    <= '0;
            rx_byte    <= '0;
            rx_d_valid <= '0;
            rx_d       <= '0;
            rx_ci      <= '0;
        end else begin
            sh         <= full[6:0];
            rx_valid   <= 1'b0;
            rx_d_valid <= '0;
            if (synced && bitn == 3'd7 && code != CODE_FREE) begin
                rx_valid <= 1'b1;
                rx_byte  <= full;
                rx_slot  <= slot;
                if (code == CODE_HANDLED && slot[1:0] == 2'd3) begin
                    rx_d_valid[ch] <= 1'b1;
                    rx_d           <= full[7:6];
                    rx_ci          <= full[5:2];
                end
            end
        end
    end

    AST_DV_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_d_valid)); // R8
    AST_DV_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_d_valid != '0) |-> rx_valid); // R8
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R7
endmodule

// File: rtl/iom_frame_handler.sv
module iom_frame_handler #(
    parameter int NCH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         fsync,
    input  logic                         rx_din,
    output logic                         tx_dout,
    input  logic                         hs_mode,
    input  logic                         cm_we,
    input  logic                         cm_init,
    input  logic                         cm_clr,
    input  logic                         cm_dir,
    input  logic                         cm_pair,
    input  logic [$clog2(NCH*4)-1:0]     cm_addr,
    input  logic [3:0]                   cm_code,
    input  logic [NCH*8-1:0]             tx_b1,
    input  logic [NCH*8-1:0]             tx_b2,
    input  logic [NCH*8-1:0]             tx_mon,
    input  logic [NCH*2-1:0]             tx_d,
    input  logic [NCH*4-1:0]             tx_ci,
    input  logic [NCH-1:0]               tx_mr,
    input  logic [NCH-1:0]               tx_mx,
    output logic                         rx_valid,
    output logic [$clog2(NCH*4)-1:0]     rx_slot,
    output logic [7:0]                   rx_byte,
    output logic [NCH-1:0]               rx_d_valid,
    output logic [1:0]                   rx_d,
    output logic [3:0]                   rx_ci
);
    import iomh_pkg::*;

    localparam int NSLOT = NCH * SLOTS_PER_CH;
    localparam int SW    = $clog2(NSLOT);

    logic               synced;
    logic [SW-1:0]      slot;
    logic [2:0]         bitn;
    logic               load;
    code_t [NSLOT-1:0]  act_up, act_dn;

    iomh_timing #(.NSLOT(NSLOT)) u_timing (
        .clk(clk), .rst_n(rst_n), .fsync(fsync),
        .synced(synced), .slot(slot), .bitn(bitn), .load(load)
    );

    iomh_ctrl_mem #(.NSLOT(NSLOT)) u_cmem (
        .clk(clk), .rst_n(rst_n), .we(cm_we), .init(cm_init), .clr(cm_clr),
        .dir(cm_dir), .pair(cm_pair), .addr(cm_addr), .code(cm_code),
        .load(load), .act_up(act_up), .act_dn(act_dn)
    );

    iomh_tx #(.NCH(NCH)) u_tx (
        .synced(synced), .slot(slot), .bitn(bitn), .act_dn(act_dn),
        .hs_mode(hs_mode), .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon),
        .tx_d(tx_d), .tx_ci(tx_ci), .tx_mr(tx_mr), .tx_mx(tx_mx),
        .tx_dout(tx_dout)
    );

    iomh_rx #(.NCH(NCH)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_din(rx_din), .synced(synced),
        .slot(slot), .bitn(bitn), .act_up(act_up),
        .rx_valid(rx_valid), .rx_slot(rx_slot), .rx_byte(rx_byte),
        .rx_d_valid(rx_d_valid), .rx_d(rx_d), .rx_ci(rx_ci)
    );

    AST_IDLE_UNSYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !synced |-> tx_dout); // R2
endmodule

// File: tb/sim_iom_frame_handler.sv
module sim_iom_frame_handler;
    localparam int NS = 32;
    localparam int FB = NS * 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0, rx_din = 1'b0, hs_mode = 1'b0;
    logic cm_we = 1'b0, cm_init = 1'b0, cm_clr = 1'b0, cm_dir = 1'b0, cm_pair = 1'b0;
    logic [4:0] cm_addr = '0;
    logic [3:0] cm_code = '0;
    logic [63:0] tx_b1 = '0, tx_b2 = '0, tx_mon = '0;
    logic [15:0] tx_d = '0;
    logic [31:0] tx_ci = '0;
    logic [7:0]  tx_mr = '0, tx_mx = '0;
    logic tx_dout, rx_valid;
    logic [4:0] rx_slot;
    logic [7:0] rx_byte, rx_d_valid;
    logic [1:0] rx_d;
    logic [3:0] rx_ci;

    iom_frame_handler u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .rx_din(rx_din), .tx_dout(tx_dout),
        .hs_mode(hs_mode), .cm_we(cm_we), .cm_init(cm_init), .cm_clr(cm_clr),
        .cm_dir(cm_dir), .cm_pair(cm_pair), .cm_addr(cm_addr), .cm_code(cm_code),
        .tx_b1(tx_b1), .tx_b2(tx_b2), .tx_mon(tx_mon), .tx_d(tx_d), .tx_ci(tx_ci),
        .tx_mr(tx_mr), .tx_mx(tx_mx), .rx_valid(rx_valid), .rx_slot(rx_slot),
        .rx_byte(rx_byte), .rx_d_valid(rx_d_valid), .rx_d(rx_d), .rx_ci(rx_ci)
    );

    always #4 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_st = 0, m_pos = FB - 1;
    logic [3:0] m_shd [2][NS];
    logic [3:0] m_act [2][NS];
    bit q [$];
    logic m_rxv = 0;
    logic [4:0] m_rxs = 0;
    logic [7:0] m_rxb = 0, m_dv = 0;
    logic [1:0] m_d = 0;
    logic [3:0] m_ci = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit m_sync();
        return fsync || (m_st == 1 && m_pos != FB - 1);
    endfunction

    function automatic int m_cp();
        return fsync ? 0 : (m_pos + 1) % FB;
    endfunction

    function automatic logic m_tx();
        int cp, s, b, ch;
        logic [3:0] c;
        logic [7:0] v;
        if (!m_sync()) return 1'b1;
        cp = m_cp(); s = cp / 8; b = cp % 8; ch = s / 4;
        c = m_act[1][s];
        if (c == 4'd0) return 1'b1;
        case (s % 4)
            0: v = tx_b1[ch*8 +: 8];
            1: v = tx_b2[ch*8 +: 8];
            2: v = tx_mon[ch*8 +: 8];
            default: v = {tx_d[ch*2 +: 2], tx_ci[ch*4 +: 4],
                          (c == 4'd2 && !hs_mode) ? 1'b1 : tx_mr[ch],
                          (c == 4'd2 && !hs_mode) ? 1'b1 : tx_mx[ch]};
        endcase
        return v[7-b];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_pos = FB - 1;
            for (int d = 0; d < 2; d++)
                for (int s = 0; s < NS; s++) begin m_shd[d][s] = 0; m_act[d][s] = 0; end
            q.delete();
            for (int k = 0; k < 8; k++) q.push_back(1'b0);
            m_rxv = 0; m_rxs = 0; m_rxb = 0; m_dv = 0; m_d = 0; m_ci = 0;
        end else begin
            bit sy;
            int cp, s;
            logic [7:0] v;
            sy = m_sync(); cp = m_cp(); s = cp / 8;
            q.push_back(rx_din);
            void'(q.pop_front());
            m_rxv = 0; m_dv = 0;
            if (sy && cp % 8 == 7 && m_act[0][s] != 0) begin
                v = 0;
                for (int k = 0; k < 8; k++) v = {v[6:0], q[k]};
                m_rxv = 1; m_rxb = v; m_rxs = 5'(s);
                if (m_act[0][s] == 4'd2 && s % 4 == 3) begin
                    m_dv[s/4] = 1'b1; m_d = v[7:6]; m_ci = v[5:2];
                end
            end
            if (cm_clr) begin
                for (int d = 0; d < 2; d++) for (int i = 0; i < NS; i++) m_shd[d][i] = 0;
            end else if (cm_init) begin
                for (int i = 0; i < NS; i++) if (((i % 4) >= 2) == cm_pair) m_shd[cm_dir][i] = cm_code;
            end else if (cm_we) m_shd[cm_dir][cm_addr] = cm_code;
            if (!sy || cp == FB - 1) m_act = m_shd;
            if (fsync) m_st = 1;
            else if (m_st == 1 && m_pos == FB - 1) m_st = 0;
            m_pos = sy ? cp : FB - 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cur_req, "tx_dout", int'(tx_dout), int'(m_tx()));
            chk(cur_req, "rx_valid", int'(rx_valid), int'(m_rxv));
            chk(cur_req, "rx_byte", int'(rx_byte), int'(m_rxb));
            chk(cur_req, "rx_slot", int'(rx_slot), int'(m_rxs));
            chk(cur_req, "rx_d_valid", int'(rx_d_valid), int'(m_dv));
            chk(cur_req, "rx_d", int'(rx_d), int'(m_d));
            chk(cur_req, "rx_ci", int'(rx_ci), int'(m_ci));
        end
    end

    task automatic cm_op(input bit we, input bit ini, input bit clr, input bit dir,
                         input bit pair, input int addr, input int code);
        cm_we = we; cm_init = ini; cm_clr = clr; cm_dir = dir; cm_pair = pair;
        cm_addr = 5'(addr); cm_code = 4'(code);
        @(posedge clk); #1;
        cm_we = 0; cm_init = 0; cm_clr = 0;
    endtask

    task automatic run_frame(input string req, input bit with_sync, input int len,
                             input int op_at, input int op_kind);
        cur_req = req;
        tx_b1 = {$urandom, $urandom}; tx_b2 = {$urandom, $urandom};
        tx_mon = {$urandom, $urandom}; tx_d = 16'($urandom); tx_ci = $urandom;
        tx_mr = 8'($urandom); tx_mx = 8'($urandom);
        for (int i = 0; i < len; i++) begin
            fsync = with_sync && (i == 0);
            rx_din = 1'($urandom);
            cm_we = 0; cm_init = 0; cm_clr = 0;
            if (i == op_at) begin
                case (op_kind)
                    1: begin cm_we = 1; cm_dir = 1; cm_addr = 5'd12; cm_code = 4'd1; end
                    2: cm_clr = 1;
                    3: begin cm_init = 1; cm_dir = 1; cm_pair = 0; cm_code = 4'd1; end
                    4: begin cm_init = 1; cm_dir = 0; cm_pair = 1; cm_code = 4'd2; end
                    default: ;
                endcase
            end
            @(posedge clk); #1;
        end
        fsync = 0; cm_we = 0; cm_init = 0; cm_clr = 0;
    endtask

    initial begin
        // R1: reset state
        repeat (5) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R1", "tx_dout in reset", int'(tx_dout), 1);
        chk("R1", "rx_valid in reset", int'(rx_valid), 0);
        chk("R1", "rx_d_valid in reset", int'(rx_d_valid), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        // R2: hunting, no sync yet
        cur_req = "R2";
        for (int i = 0; i < 20; i++) begin rx_din = 1'($urandom); @(posedge clk); #1; end
        // R10: priority checks, then programming while hunting
        cur_req = "R10";
        cm_op(1, 1, 0, 1, 0, 20, 3);
        cm_op(1, 0, 1, 1, 0, 21, 3);
        cur_req = "R9";
        cm_op(0, 1, 0, 0, 1, 0, 2);
        cm_op(0, 1, 0, 1, 1, 0, 2);
        cm_op(1, 0, 0, 1, 0, 0, 1);
        cm_op(1, 0, 0, 1, 0, 1, 1);
        cm_op(1, 0, 0, 1, 0, 5, 1);
        cm_op(1, 0, 0, 1, 0, 7, 1);
        cm_op(1, 0, 0, 0, 0, 4, 1);
        cm_op(1, 0, 0, 0, 0, 9, 1);
        cm_op(1, 0, 0, 0, 0, 3, 1);
        hs_mode = 0; run_frame("R5", 1, FB, -1, 0);
        hs_mode = 1; run_frame("R4", 1, FB, -1, 0);
        run_frame("R3", 1, FB, -1, 0);
        hs_mode = 0; run_frame("R7", 1, FB, -1, 0);
        run_frame("R8", 1, FB, -1, 0);
        run_frame("R11", 1, FB, 100, 1);
        run_frame("R11", 1, FB, -1, 0);
        run_frame("R10", 1, FB, 50, 3);
        run_frame("R3", 1, FB, -1, 0);
        run_frame("R6", 1, FB, 30, 2);
        run_frame("R6", 1, FB, -1, 0);
        run_frame("R9", 1, FB, 10, 4);
        run_frame("R9", 1, FB, -1, 0);
        cm_op(0, 1, 0, 1, 1, 0, 2);
        run_frame("R12", 1, 100, -1, 0);
        run_frame("R12", 1, FB, -1, 0);
        run_frame("R12", 0, FB, -1, 0);
        run_frame("R12", 1, FB, -1, 0);
        run_frame("R2", 1, FB, -1, 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule